// File: doc/BRIEF.md
# Rise/Fall Point PWM Generator

This block drives a set of fan PWM pins. Three independent clock types each own a prescaler and a period counter. The prescaler has two stages: a power-of-two stage followed by an even-integer stage. The period counter runs from zero up to a programmed unit value and then wraps. Each output port follows one of the three clock types. It goes high and low at two programmed 8-bit count points inside that type's period, so the duty cycle and the phase of the pulse are both set by software.

Software programs the block through a plain register write port (enable, address, 32-bit data). Changes to timing and compare points are held back until the next period boundary, so a write made mid-period never produces a cut-short or stretched pulse. A global run bit stops every counter and forces every pin low.

Top module: `pwm_rf_gen`

## Requirements
- R1: After reset every register field is zero, the block is stopped and every `pwm_o` bit is low.
- R2: The first prescaler stage of a clock type divides the clock by 2 to the power of its 4-bit H field (bits [7:4] of the type's 16-bit group).
- R3: The second prescaler stage divides by 1 when its 4-bit L field (bits [3:0] of the group) is zero, and by 2×L otherwise.
- R4: A period lasts unit+1 prescaled ticks (unit in bits [15:8] of the group), so one period is 2^H × Ldiv × (unit+1) clock cycles.
- R5: With count c, rise point r and fall point f, a port is high when r ≤ c < f if r < f, and high when c ≥ r or c < f otherwise. Equal points, including both zero, give a constant high. The pin changes one cycle after the count it reflects.
- R6: Duty register at address 3+k holds port 2k in bits [15:0] and port 2k+1 in bits [31:16]; inside each half the rise point is bits [7:0] and the fall point bits [15:8].
- R7: Address 1 holds clock type M in bits [15:0] and type N in bits [31:16]. Address 2 holds type O in bits [15:0].
- R8: At control address 0, bit 12+p holds bit 0 of port p's type select and bit 3+p holds bit 1. Select 0 picks M, 1 picks N, and 2 or 3 pick O. A change of select takes effect at once.
- R9: Control bit 8+p enables port p. A disabled port drives low and does not disturb the other ports.
- R10: New H, L, unit, rise and fall values take effect only when the affected period wraps from unit to zero, or at once while the block is stopped.
- R11: While control bit 0 (run) is clear, every prescaler and period counter is held at zero and every pin is low. Counting starts from zero on the first cycle after run is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 32 | Register write data |
| pwm_o | output | NUM_PORTS | PWM output pins |

## Verification
A register write is captured on the clock edge where `wr_en` is high. Its effect starts in the state after that edge. A pin always shows the window test of the count held one cycle earlier, so each pin value is due one clock after the count and shadow state it depends on. The bench model steps on each rising edge in the same order: it first forms the pin value from the old count, then advances the counters and loads the shadows, and then applies the write. The pins are compared on the falling edge, half a cycle after the value was registered. Duty-ratio and edge-count checks are made over whole windows of 40 or 80 cycles taken in steady state, so they do not depend on phase alignment.

// File: rtl/pwm_rf_pkg.sv
package pwm_rf_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_TYPES = 3;
    localparam int CNT_W     = 8;
    localparam int DIV_W     = 4;
    localparam int HCNT_W    = (1 << DIV_W) - 1;
    localparam int LCNT_W    = DIV_W + 1;

    // register word addresses
    localparam int A_CTRL   = 0;
    localparam int A_CLK_MN = 1;
    localparam int A_CLK_O  = 2;
    localparam int A_DUTY0  = 3;

    // control word bit positions
    localparam int B_RUN     = 0;
    localparam int B_EN0     = 8;
    localparam int B_SEL0_LO = 12;
    localparam int B_SEL0_HI = 3;

    typedef struct packed {
        logic [CNT_W-1:0] unit;
        logic [DIV_W-1:0] hexp;
        logic [DIV_W-1:0] lsel;
    } clk_cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] fall;
        logic [CNT_W-1:0] rise;
    } duty_t;

endpackage

// File: rtl/pwm_rf_regs.sv
module pwm_rf_regs
    import pwm_rf_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic                          run_o,
    output logic [NUM_PORTS-1:0]          port_en_o,
    output logic [NUM_PORTS-1:0][1:0]     port_sel_o,
    output clk_cfg_t [NUM_TYPES-1:0]      cfg_o,
    output duty_t [NUM_PORTS-1:0]         duty_o
);

    localparam int NUM_DUTY = NUM_PORTS / 2;

    typedef struct packed {
        logic                         run;
        logic [NUM_PORTS-1:0]         en;
        logic [NUM_PORTS-1:0]         sel_lo;
        logic [NUM_PORTS-1:0]         sel_hi;
        clk_cfg_t [NUM_TYPES-1:0]     cfg;
        duty_t [NUM_PORTS-1:0]        duty;
    } reg_state_t;

    reg_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(A_CTRL)) begin
                st_d.run = wr_data[B_RUN];
                for (int p = 0; p < NUM_PORTS; p++) begin
                    st_d.en[p]     = wr_data[B_EN0 + p];
                    st_d.sel_lo[p] = wr_data[B_SEL0_LO + p];
                    st_d.sel_hi[p] = wr_data[B_SEL0_HI + p];
                end
            end
            if (wr_addr == ADDR_W'(A_CLK_MN)) begin
                st_d.cfg[0] = clk_cfg_t'(wr_data[15:0]);
                st_d.cfg[1] = clk_cfg_t'(wr_data[31:16]);
            end
            if (wr_addr == ADDR_W'(A_CLK_O)) begin
                st_d.cfg[2] = clk_cfg_t'(wr_data[15:0]);
            end
            for (int k = 0; k < NUM_DUTY; k++) begin
                if (wr_addr == ADDR_W'(A_DUTY0 + k)) begin
                    st_d.duty[2*k]   = duty_t'(wr_data[15:0]);
                    st_d.duty[2*k+1] = duty_t'(wr_data[31:16]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o     = st_q.run;
    assign port_en_o = st_q.en;
    assign cfg_o     = st_q.cfg;
    assign duty_o    = st_q.duty;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sel
        assign port_sel_o[p] = {st_q.sel_hi[p], st_q.sel_lo[p]};
    end

endmodule

// File: rtl/pwm_rf_timebase.sv
module pwm_rf_timebase
    import pwm_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  clk_cfg_t         cfg_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o
);

    localparam logic [HCNT_W-1:0] H_ONE = HCNT_W'(1);
    localparam logic [LCNT_W-1:0] L_ONE = LCNT_W'(1);
    localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

    typedef struct packed {
        logic [HCNT_W-1:0] hcnt;
        logic [LCNT_W-1:0] lcnt;
        logic [CNT_W-1:0]  cnt;
        clk_cfg_t          act;
    } tb_state_t;

    tb_state_t st_q, st_d;
    logic [HCNT_W-1:0] hmax;
    logic [LCNT_W-1:0] lmax;
    logic hlast, tick, wrap;

    always_comb begin
        hmax  = HCNT_W'((32'd1 << st_q.act.hexp) - 32'd1);
        lmax  = (st_q.act.lsel == '0) ? '0 : ({st_q.act.lsel, 1'b0} - L_ONE);
        hlast = (st_q.hcnt == hmax);
        tick  = hlast && (st_q.lcnt == lmax);
        wrap  = tick && (st_q.cnt == st_q.act.unit);
        load_o = !run || wrap;

        st_d = st_q;
        if (!run) begin
            st_d.hcnt = '0;
            st_d.lcnt = '0;
            st_d.cnt  = '0;
            st_d.act  = cfg_i;
        end else begin
            st_d.hcnt = hlast ? '0 : st_q.hcnt + H_ONE;
            if (hlast)
                st_d.lcnt = (st_q.lcnt == lmax) ? '0 : st_q.lcnt + L_ONE;
            if (tick)
                st_d.cnt = wrap ? '0 : st_q.cnt + C_ONE;
            if (wrap)
                st_d.act = cfg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/pwm_rf_port.sv
module pwm_rf_port
    import pwm_rf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt,
    input  duty_t            duty_i,
    output logic             pwm_o
);

    typedef struct packed {
        duty_t act;
        logic  pwm;
    } port_state_t;

    port_state_t st_q, st_d;
    logic in_win;

    always_comb begin
        if (st_q.act.rise < st_q.act.fall)
            in_win = (cnt >= st_q.act.rise) && (cnt < st_q.act.fall);
        else
            in_win = (cnt >= st_q.act.rise) || (cnt < st_q.act.fall);

        st_d     = st_q;
        st_d.pwm = run && en && in_win;
        if (load)
            st_d.act = duty_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = st_q.pwm;

endmodule

// File: rtl/pwm_rf_gen.sv
module pwm_rf_gen
    import pwm_rf_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    output logic [NUM_PORTS-1:0] pwm_o
);

    logic                            run;
    logic [NUM_PORTS-1:0]            port_en;
    logic [NUM_PORTS-1:0][1:0]       port_sel;
    clk_cfg_t [NUM_TYPES-1:0]        cfg;
    duty_t [NUM_PORTS-1:0]           duty;
    logic [NUM_TYPES-1:0][CNT_W-1:0] tb_cnt;
    logic [NUM_TYPES-1:0]            tb_load;

    pwm_rf_regs #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .run_o      (run),
        .port_en_o  (port_en),
        .port_sel_o (port_sel),
        .cfg_o      (cfg),
        .duty_o     (duty)
    );

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
        pwm_rf_timebase u_tb (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .cfg_i  (cfg[t]),
            .cnt_o  (tb_cnt[t]),
            .load_o (tb_load[t])
        );
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [CNT_W-1:0] sel_cnt;
        logic             sel_load;

        always_comb begin
            if (port_sel[p][1]) begin
                sel_cnt  = tb_cnt[2];
                sel_load = tb_load[2];
            end else if (port_sel[p][0]) begin
                sel_cnt  = tb_cnt[1];
                sel_load = tb_load[1];
            end else begin
                sel_cnt  = tb_cnt[0];
                sel_load = tb_load[0];
            end
        end

        pwm_rf_port u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .en     (port_en[p]),
            .load   (sel_load),
            .cnt    (sel_cnt),
            .duty_i (duty[p]),
            .pwm_o  (pwm_o[p])
        );
    end

endmodule

// File: rtl/pwm_rf_gen_chk.sv
module pwm_rf_gen_chk
    import pwm_rf_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            run,
    input logic [NUM_PORTS-1:0]            port_en,
    input logic [NUM_TYPES-1:0][CNT_W-1:0] cnt,
    input logic [NUM_TYPES-1:0]            load,
    input logic [NUM_PORTS-1:0]            pwm_o
);

    // R11: stopped block gives all-low pins on the next cycle
    a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pwm_o == '0));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_p
        // R9: disabled port is low on the next cycle
        a_r9_port_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            !port_en[p] |=> !pwm_o[p]);
    end

    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_t
        // R4: a boundary (or stop) returns the period count to zero
        a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
            load[t] |=> (cnt[t] == '0));
        // R10: the period count only holds, steps by one, or restarts
        a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            run |=> ((cnt[t] == $past(cnt[t])) ||
                     (cnt[t] == $past(cnt[t]) + 8'd1) ||
                     (cnt[t] == '0)));
    end

endmodule

bind pwm_rf_gen pwm_rf_gen_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .port_en (port_en),
    .cnt     (tb_cnt),
    .load    (tb_load),
    .pwm_o   (pwm_o)
);

// File: tb/pwm_rf_gen_bench.sv
module pwm_rf_gen_bench;

    localparam int NP = 4;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [NP-1:0] pwm_o;

    always #5 clk = ~clk;

    pwm_rf_gen #(.NUM_PORTS(NP), .ADDR_W(AW)) u_pwm_rf_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_o   (pwm_o)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R5";
    bit    cmp_on = 1'b0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0]   m_ctrl = '0, m_clka = '0;
    logic [15:0]   m_clkb = '0;
    logic [31:0]   m_duty [2] = '{default: '0};
    int            m_ph [3] = '{default: 0};
    int            m_cnt [3] = '{default: 0};
    int            m_da [3] = '{default: 1};
    int            m_ua [3] = '{default: 0};
    int            m_ra [NP] = '{default: 0};
    int            m_fa [NP] = '{default: 0};
    logic [2:0]    m_bnd;
    logic [15:0]   m_tmp;
    logic [NP-1:0] exp_pwm = '0;

    function automatic int f_div(int h, int l);
        return (1 << h) * ((l == 0) ? 1 : 2 * l);
    endfunction

    function automatic int f_type(logic [31:0] c, int p);
        if (c[3 + p]) return 2;
        return c[12 + p] ? 1 : 0;
    endfunction

    function automatic bit f_win(int c, int r, int f);
        if (r < f) return (c >= r) && (c < f);
        return (c >= r) || (c < f);
    endfunction

    function automatic logic [15:0] f_cfg(int t);
        if (t == 0) return m_clka[15:0];
        if (t == 1) return m_clka[31:16];
        return m_clkb;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = '0; m_clka = '0; m_clkb = '0;
            m_duty[0] = '0; m_duty[1] = '0;
            for (int t = 0; t < 3; t++) begin
                m_ph[t] = 0; m_cnt[t] = 0; m_da[t] = 1; m_ua[t] = 0;
            end
            for (int p = 0; p < NP; p++) begin
                m_ra[p] = 0; m_fa[p] = 0;
            end
            exp_pwm = '0;
        end else begin
            for (int p = 0; p < NP; p++)
                exp_pwm[p] = m_ctrl[0] && m_ctrl[8 + p] &&
                             f_win(m_cnt[f_type(m_ctrl, p)], m_ra[p], m_fa[p]);
            for (int t = 0; t < 3; t++) begin
                if (!m_ctrl[0]) begin
                    m_bnd[t] = 1'b1; m_ph[t] = 0; m_cnt[t] = 0;
                end else begin
                    m_bnd[t] = (m_ph[t] == m_da[t] - 1) && (m_cnt[t] == m_ua[t]);
                    if (m_ph[t] == m_da[t] - 1) begin
                        m_ph[t] = 0;
                        m_cnt[t] = (m_cnt[t] == m_ua[t]) ? 0 : m_cnt[t] + 1;
                    end else begin
                        m_ph[t] = m_ph[t] + 1;
                    end
                end
                if (m_bnd[t]) begin
                    m_tmp = f_cfg(t);
                    m_da[t] = f_div(int'(m_tmp[7:4]), int'(m_tmp[3:0]));
                    m_ua[t] = int'(m_tmp[15:8]);
                end
            end
            for (int p = 0; p < NP; p++) begin
                if (m_bnd[f_type(m_ctrl, p)]) begin
                    m_tmp = (p % 2 == 1) ? m_duty[p / 2][31:16] : m_duty[p / 2][15:0];
                    m_ra[p] = int'(m_tmp[7:0]);
                    m_fa[p] = int'(m_tmp[15:8]);
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_ctrl = wr_data;
                    3'd1: m_clka = wr_data;
                    3'd2: m_clkb = wr_data[15:0];
                    3'd3: m_duty[0] = wr_data;
                    3'd4: m_duty[1] = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n)
            for (int p = 0; p < NP; p++)
                check(tag, int'(pwm_o[p]), int'(exp_pwm[p]));
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(int n, output int hi [NP], output int rises [NP]);
        logic [NP-1:0] prev;
        for (int p = 0; p < NP; p++) begin hi[p] = 0; rises[p] = 0; end
        prev = pwm_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            for (int p = 0; p < NP; p++) begin
                if (pwm_o[p]) hi[p]++;
                if (pwm_o[p] && !prev[p]) rises[p]++;
            end
            prev = pwm_o;
        end
    endtask

    function automatic logic [15:0] rnd_clk();
        logic [3:0] l = 4'($urandom_range(0, 3));
        logic [3:0] h = 4'($urandom_range(0, 2));
        logic [7:0] u = 8'($urandom_range(0, 15));
        return {u, h, l};
    endfunction

    function automatic logic [31:0] rnd_duty();
        logic [31:0] d;
        d[7:0]   = 8'($urandom_range(0, 17));
        d[15:8]  = 8'($urandom_range(0, 17));
        d[23:16] = 8'($urandom_range(0, 17));
        d[31:24] = 8'($urandom_range(0, 17));
        return d;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int hi [NP];
        int rs [NP];
        void'($urandom(32'd20240));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(pwm_o), 0);
        cmp_on = 1'b1;

        // R11: enables and selects set, run clear -> all low
        wr(0, 32'h0000_AF60);
        measure(40, hi, rs);
        check("R11", hi[0] + hi[1] + hi[2] + hi[3], 0);

        // M: L=2 H=1 U=4 (40 cycles); N: L=0 H=0 U=9 (10); O: L=0 H=2 U=1 (8)
        wr(1, 32'h0900_0412);
        wr(2, 32'h0000_0120);
        wr(3, 32'h0000_0301);   // p0 rise1 fall3, p1 rise0 fall0
        wr(4, 32'h0100_0001);   // p2 rise1 fall0, p3 rise0 fall1
        wr(0, 32'h0000_AF61);   // run, all enabled, p1=N, p2=O, p3=sel3
        repeat (100) @(negedge clk);
        measure(40, hi, rs);
        check("R3", hi[0], 16);
        check("R5", hi[1], 40);
        check("R2 R6", hi[2], 20);
        check("R8", hi[3], 20);
        measure(80, hi, rs);
        check("R4", rs[0], 2);
        check("R4", rs[2], 10);
        check("R5", rs[1], 0);

        // R9: disable port 0 only
        wr(0, 32'h0000_AE61);
        repeat (3) @(negedge clk);
        measure(40, hi, rs);
        check("R9", hi[0], 0);
        check("R9", hi[3], 20);

        // R7: N type in the high half, port 1 fall point 5
        wr(3, 32'h0500_0301);
        repeat (30) @(negedge clk);
        measure(40, hi, rs);
        check("R7", hi[1], 20);

        // R11: stop
        wr(0, 32'h0000_0000);
        repeat (2) @(negedge clk);
        measure(40, hi, rs);
        check("R11", hi[0] + hi[1] + hi[2] + hi[3], 0);

        // R10: random configurations with writes while running
        tag = "R10";
        for (int trial = 0; trial < 30; trial++) begin
            wr(0, 32'h0);
            wr(1, {rnd_clk(), rnd_clk()});
            wr(2, {16'h0, rnd_clk()});
            wr(3, rnd_duty());
            wr(4, rnd_duty());
            wr(0, ($urandom & 32'h0000_FF78) | 32'h1);
            for (int k = 0; k < 3; k++) begin
                int a;
                repeat ($urandom_range(40, 120)) @(negedge clk);
                a = $urandom_range(0, 4);
                case (a)
                    0: wr(0, ($urandom & 32'h0000_FF78) | 32'h1);
                    1: wr(1, {rnd_clk(), rnd_clk()});
                    2: wr(2, {16'h0, rnd_clk()});
                    default: wr(a, rnd_duty());
                endcase
            end
            repeat (60) @(negedge clk);
        end

        cmp_on = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule